// File: doc/BRIEF.md
# Burst Sample Capture Controller

This block takes one unbroken record of converter samples at the full sample rate and then empties that record slowly toward a byte-wide serial transmitter. On the sample clock, it writes a run of 2^ADDR_W consecutive samples into an external buffer. Each sample is zero-extended from the selected converter width and kept in the converter's own two's-complement coding. When the run is complete, writing stops. A toggle flag crosses into the read clock domain, and the block then reads the buffer back one word at a time. It presents each word as three bytes on a valid/ready byte stream.

A start command on the read side arms a capture. Further start commands are ignored until the current record has been fully drained. The block also drives a reference clock at half the sample clock rate for phase locking an external source. With the default parameter the record holds 32768 samples.

Top module: `burst_capture_ctrl`

## Requirements
- R1: After a start, the buffer write enable is high on exactly 2^ADDR_W consecutive sample clock cycles, with addresses 0, 1, 2 and so on up to 2^ADDR_W-1 in that order. It then stays low until the next accepted start.
- R2: The word written at address k is the sample presented on the k-th cycle of the run. It is written in the converter's coding, with no inversion or offset applied.
- R3: The width select `wid_sel` is read as follows: 00 gives 18 bits, 01 gives 16, 10 gives 14 and 11 gives 12. Written words keep the low bits of the sample and have every bit above the selected width forced to 0.
- R4: No buffer read is issued before the whole record has been written. The completion flag passes through a two-flop synchronizer into the read domain. Each read asserts `buf_re` for one cycle, and read data is expected on the next read clock cycle.
- R5: Each stored 18-bit word is sent as three bytes, most significant first: {6'b0, w[17:16]}, then w[15:8], then w[7:0]. `tx_byte` holds steady while `tx_valid` waits for `tx_ready`.
- R6: `data_avail` is low during capture. It goes high when draining begins and stays high while bytes are offered. It drops after the last byte of the last word has been accepted.
- R7: A start asserted while a capture or a drain is in progress has no effect: no further record is written and no further bytes are sent.
- R8: `clk_half` inverts on every sample clock edge outside reset, giving the sample clock divided by two.
- R9: Every accepted start begins a new record at address 0, whatever the previous record ended with.
- R10: In reset, the write enable, read enable, `tx_valid`, `data_avail` and `clk_half` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Sample (data-ready) clock |
| rst_smp | input | 1 | Synchronous active-high reset, sample domain |
| smp_data | input | 18 | Parallel converter sample, right-aligned |
| wid_sel | input | 2 | Converter width select |
| clk_rd | input | 1 | Slow read and transmit clock |
| rst_rd | input | 1 | Synchronous active-high reset, read domain |
| start | input | 1 | Capture request, read domain |
| buf_we | output | 1 | Buffer write enable |
| buf_waddr | output | ADDR_W | Buffer write address |
| buf_wdata | output | 18 | Buffer write word |
| buf_re | output | 1 | Buffer read enable |
| buf_raddr | output | ADDR_W | Buffer read address |
| buf_rdata | input | 18 | Buffer read word, one cycle after `buf_re` |
| tx_byte | output | 8 | Byte offered to the serial transmitter |
| tx_valid | output | 1 | Byte offered |
| tx_ready | input | 1 | Transmitter accepts the byte |
| data_avail | output | 1 | Captured data waiting to be sent |
| clk_half | output | 1 | Sample clock divided by two |

## Verification
A wrong write counter shows at the ports within one sample cycle, as an address out of order or a run of the wrong length. A dropped or duplicated sample shows as the first wrong word on the write bus. A bad width mask shows as a nonzero upper bit in the very first written word. Faults in the read-side state machine appear as a wrong byte order or as early reads. They can also appear as `data_avail` dropping before the count of 3·2^ADDR_W bytes has been reached. All of these show during the first drain. A start that is wrongly accepted shows as a second burst of writes within a few cycles of the synchronizer delay.

// File: rtl/burst_cap_pkg.sv
package burst_cap_pkg;

    localparam int SMP_W         = 18;
    localparam int BYTE_W        = 8;
    localparam int BYTES_PER_SMP = 3;

    typedef logic [SMP_W-1:0]  sample_t;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        WID_18 = 2'b00,
        WID_16 = 2'b01,
        WID_14 = 2'b10,
        WID_12 = 2'b11
    } width_sel_e;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_WAIT,
        RD_FETCH,
        RD_LOAD,
        RD_SEND
    } rd_state_e;

    typedef struct packed {
        sample_t    word;
        logic [1:0] idx;
    } tx_slot_t;

    function automatic sample_t width_mask(width_sel_e sel);
        case (sel)
            WID_16:  return sample_t'(18'h0FFFF);
            WID_14:  return sample_t'(18'h03FFF);
            WID_12:  return sample_t'(18'h00FFF);
            default: return '1;
        endcase
    endfunction

    function automatic byte_t byte_of(sample_t w, logic [1:0] idx);
        logic [BYTES_PER_SMP*BYTE_W-1:0] ext;
        ext = {{(BYTES_PER_SMP*BYTE_W-SMP_W){1'b0}}, w};
        case (idx)
            2'd0:    return ext[23:16];
            2'd1:    return ext[15:8];
            default: return ext[7:0];
        endcase
    endfunction

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/capture_writer.sv
module capture_writer
    import burst_cap_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_tog,
    input  logic [1:0]        wid_sel,
    input  sample_t           smp_data,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output sample_t           buf_wdata,
    output logic              done_tog,
    output logic              clk_half
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic              req_s;
    logic              req_seen;
    logic              active;
    logic [ADDR_W-1:0] cnt;

    bit_sync #(.STAGES(2)) u_req_sync (
        .clk (clk),
        .rst (rst),
        .d   (req_tog),
        .q   (req_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_half  <= 1'b0;
            req_seen  <= 1'b0;
            active    <= 1'b0;
            cnt       <= '0;
            buf_we    <= 1'b0;
            buf_waddr <= '0;
            buf_wdata <= '0;
            done_tog  <= 1'b0;
        end else begin
            clk_half  <= ~clk_half;
            req_seen  <= req_s;
            buf_we    <= active;
            buf_waddr <= cnt;
            buf_wdata <= smp_data & width_mask(width_sel_e'(wid_sel));
            if (buf_we && buf_waddr == LAST_ADDR) done_tog <= ~done_tog;
            if (active) begin
                cnt <= cnt + 1'b1;
                if (cnt == LAST_ADDR) active <= 1'b0;
            end else if (req_s != req_seen) begin
                active <= 1'b1;
                cnt    <= '0;
            end
        end
    end
endmodule

// File: rtl/drain_reader.sv
module drain_reader
    import burst_cap_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done_tog,
    output logic              req_tog,
    output logic              buf_re,
    output logic [ADDR_W-1:0] buf_raddr,
    input  sample_t           buf_rdata,
    output byte_t             tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              data_avail
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
    localparam logic [1:0]        LAST_BYTE = 2'(BYTES_PER_SMP - 1);

    rd_state_e         st;
    tx_slot_t          slot;
    logic [ADDR_W-1:0] raddr;
    logic              done_s;
    logic              done_seen;

    bit_sync #(.STAGES(2)) u_done_sync (
        .clk (clk),
        .rst (rst),
        .d   (done_tog),
        .q   (done_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= RD_IDLE;
            slot      <= '0;
            raddr     <= '0;
            req_tog   <= 1'b0;
            done_seen <= 1'b0;
        end else begin
            done_seen <= done_s;
            case (st)
                RD_IDLE: if (start) begin
                    req_tog <= ~req_tog;
                    st      <= RD_WAIT;
                end
                RD_WAIT: if (done_s != done_seen) begin
                    raddr <= '0;
                    st    <= RD_FETCH;
                end
                RD_FETCH: st <= RD_LOAD;
                RD_LOAD: begin
                    slot.word <= buf_rdata;
                    slot.idx  <= 2'd0;
                    st        <= RD_SEND;
                end
                RD_SEND: if (tx_ready) begin
                    if (slot.idx == LAST_BYTE) begin
                        if (raddr == LAST_ADDR) begin
                            st <= RD_IDLE;
                        end else begin
                            raddr <= raddr + 1'b1;
                            st    <= RD_FETCH;
                        end
                    end else begin
                        slot.idx <= slot.idx + 1'b1;
                    end
                end
                default: st <= RD_IDLE;
            endcase
        end
    end

    always_comb begin
        buf_re     = (st == RD_FETCH);
        buf_raddr  = raddr;
        tx_valid   = (st == RD_SEND);
        tx_byte    = byte_of(slot.word, slot.idx);
        data_avail = (st == RD_FETCH) || (st == RD_LOAD) || (st == RD_SEND);
    end
endmodule

// File: rtl/burst_capture_ctrl.sv
module burst_capture_ctrl
    import burst_cap_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk_smp,
    input  logic              rst_smp,
    input  logic [17:0]       smp_data,
    input  logic [1:0]        wid_sel,
    input  logic              clk_rd,
    input  logic              rst_rd,
    input  logic              start,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_waddr,
    output logic [17:0]       buf_wdata,
    output logic              buf_re,
    output logic [ADDR_W-1:0] buf_raddr,
    input  logic [17:0]       buf_rdata,
    output logic [7:0]        tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic              data_avail,
    output logic              clk_half
);
    logic req_tog;
    logic done_tog;

    capture_writer #(.ADDR_W(ADDR_W)) u_writer (
        .clk       (clk_smp),
        .rst       (rst_smp),
        .req_tog   (req_tog),
        .wid_sel   (wid_sel),
        .smp_data  (smp_data),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_wdata (buf_wdata),
        .done_tog  (done_tog),
        .clk_half  (clk_half)
    );

    drain_reader #(.ADDR_W(ADDR_W)) u_reader (
        .clk        (clk_rd),
        .rst        (rst_rd),
        .start      (start),
        .done_tog   (done_tog),
        .req_tog    (req_tog),
        .buf_re     (buf_re),
        .buf_raddr  (buf_raddr),
        .buf_rdata  (buf_rdata),
        .tx_byte    (tx_byte),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .data_avail (data_avail)
    );
endmodule

// File: rtl/burst_capture_chk.sv
module burst_capture_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk_smp,
    input logic              rst_smp,
    input logic [1:0]        wid_sel,
    input logic              clk_rd,
    input logic              rst_rd,
    input logic              buf_we,
    input logic [ADDR_W-1:0] buf_waddr,
    input logic [17:0]       buf_wdata,
    input logic              buf_re,
    input logic [7:0]        tx_byte,
    input logic              tx_valid,
    input logic              tx_ready,
    input logic              data_avail,
    input logic              clk_half
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    // R1: addresses advance by one on consecutive cycles
    assert_addr_step_R1: assert property (@(posedge clk_smp) disable iff (rst_smp)
        (buf_we && buf_waddr != LAST_ADDR) |=> (buf_we && buf_waddr == $past(buf_waddr) + 1'b1));

    // R1: writing stops after the last address
    assert_stop_after_last_R1: assert property (@(posedge clk_smp) disable iff (rst_smp)
        (buf_we && buf_waddr == LAST_ADDR) |=> !buf_we);

    // R3: 12-bit selection clears the upper bits
    assert_upper_zero_R3: assert property (@(posedge clk_smp) disable iff (rst_smp)
        (wid_sel == 2'b11) |=> (!buf_we || buf_wdata[17:12] == 6'd0));

    // R4: each read is a single-cycle pulse
    assert_single_read_R4: assert property (@(posedge clk_rd) disable iff (rst_rd)
        buf_re |=> !buf_re);

    // R5: an offered byte is held until accepted
    assert_hold_byte_R5: assert property (@(posedge clk_rd) disable iff (rst_rd)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));

    // R6: bytes are offered only while data is flagged available
    assert_avail_covers_tx_R6: assert property (@(posedge clk_rd) disable iff (rst_rd)
        (tx_valid || buf_re) |-> data_avail);

    // R8: divided clock inverts on every edge
    assert_half_toggle_R8: assert property (@(posedge clk_smp) disable iff (rst_smp)
        !rst_smp |=> (clk_half != $past(clk_half)));
endmodule

bind burst_capture_ctrl burst_capture_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk_smp    (clk_smp),
    .rst_smp    (rst_smp),
    .wid_sel    (wid_sel),
    .clk_rd     (clk_rd),
    .rst_rd     (rst_rd),
    .buf_we     (buf_we),
    .buf_waddr  (buf_waddr),
    .buf_wdata  (buf_wdata),
    .buf_re     (buf_re),
    .tx_byte    (tx_byte),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .data_avail (data_avail),
    .clk_half   (clk_half)
);

// File: tb/test_burst_capture_ctrl.sv
`timescale 1ns/1ps
module test_burst_capture_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int SMP_PERIOD = 4;
    localparam int ADDR_W     = 5;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int WATCHDOG   = 20000;

    logic              clk_smp = 1'b0;
    logic              clk_rd  = 1'b0;
    logic              rst_smp = 1'b1;
    logic              rst_rd  = 1'b1;
    logic [17:0]       smp_data = 18'h2A5C3;
    logic [1:0]        wid_sel = 2'b00;
    logic              start = 1'b0;
    logic              buf_we, buf_re, tx_valid, data_avail, clk_half;
    logic [ADDR_W-1:0] buf_waddr, buf_raddr;
    logic [17:0]       buf_wdata;
    logic [17:0]       buf_rdata = '0;
    logic [7:0]        tx_byte;
    logic              tx_ready = 1'b0;

    always #(SMP_PERIOD/2) clk_smp = ~clk_smp;
    always #(CLK_PERIOD/2) clk_rd  = ~clk_rd;

    burst_capture_ctrl #(.ADDR_W(ADDR_W)) i_burst_capture_ctrl (
        .clk_smp(clk_smp), .rst_smp(rst_smp), .smp_data(smp_data), .wid_sel(wid_sel),
        .clk_rd(clk_rd), .rst_rd(rst_rd), .start(start),
        .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata),
        .buf_re(buf_re), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .data_avail(data_avail), .clk_half(clk_half)
    );

    // external buffer model
    logic [17:0] mem [DEPTH];
    always @(posedge clk_smp) if (buf_we) mem[buf_waddr] <= buf_wdata;
    always @(posedge clk_rd)  if (buf_re) buf_rdata <= mem[buf_raddr];

    int checks = 0;
    int failures = 0;
    logic [17:0] rec [DEPTH];
    int exp_addr = 0;
    int run_writes = 0;
    int bytes_got = 0;
    int rd_cyc = 0;
    bit half_known = 0;
    logic half_prev = 1'b0;
    logic we_prev = 1'b0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [17:0] exp_mask(input logic [1:0] w);
        return 18'h3FFFF >> (2 * int'(w));
    endfunction

    function automatic logic [7:0] exp_byte(input logic [17:0] w, input int k);
        logic [23:0] e;
        e = {6'b0, w};
        return e[8*(2-k) +: 8];
    endfunction

    // sample-domain reference model, compared every sample clock
    always @(negedge clk_smp) begin
        if (!rst_smp) begin
            if (half_known) chk(clk_half != half_prev, "R8", clk_half, !half_prev);
            half_known = 1;
            half_prev  = clk_half;
            if (buf_we) begin
                if (exp_addr == 0) chk(!data_avail, "R6 low during capture", data_avail, 0);
                chk(int'(buf_waddr) == exp_addr, "R1/R9 address", buf_waddr, exp_addr);
                chk(buf_wdata == (smp_data & exp_mask(wid_sel)), "R2/R3 word",
                    buf_wdata, smp_data & exp_mask(wid_sel));
                if (exp_addr < DEPTH) rec[exp_addr] = smp_data & exp_mask(wid_sel);
                exp_addr++;
                run_writes++;
            end else if (we_prev) begin
                chk(exp_addr == DEPTH, "R1 contiguous run", exp_addr, DEPTH);
            end
            we_prev = buf_we;
            smp_data = {smp_data[16:0], smp_data[17] ^ smp_data[12]} ^ 18'h1B35;
        end
    end

    // read-domain reference model
    always @(negedge clk_rd) begin
        rd_cyc++;
        tx_ready = (rd_cyc % 3) != 1;
        if (!rst_rd) begin
            if (buf_re) chk(run_writes == DEPTH, "R4 read after full record", run_writes, DEPTH);
            if (tx_valid) chk(data_avail, "R6 high while sending", data_avail, 1);
            if (tx_valid && tx_ready) begin
                if (bytes_got < 3*DEPTH)
                    chk(tx_byte == exp_byte(rec[bytes_got/3], bytes_got%3), "R5 byte",
                        tx_byte, exp_byte(rec[bytes_got/3], bytes_got%3));
                else
                    chk(0, "R7 extra byte", bytes_got, 3*DEPTH);
                bytes_got++;
            end
        end
    end

    task automatic pulse_start();
        @(negedge clk_rd) start = 1'b1;
        @(negedge clk_rd) start = 1'b0;
    endtask

    task automatic run(input logic [1:0] w, input bit poke);
        wid_sel    = w;
        exp_addr   = 0;
        run_writes = 0;
        bytes_got  = 0;
        pulse_start();
        if (poke) begin
            repeat (2) @(negedge clk_rd);
            pulse_start();
        end
        while (!data_avail) @(negedge clk_rd);
        chk(run_writes == DEPTH, "R1 record length", run_writes, DEPTH);
        if (poke) begin
            while (bytes_got < 10) @(negedge clk_rd);
            pulse_start();
        end
        while (data_avail) @(negedge clk_rd);
        chk(bytes_got == 3*DEPTH, "R6 falls after last byte", bytes_got, 3*DEPTH);
        repeat (60) @(negedge clk_rd);
        chk(run_writes == DEPTH, "R7 no extra capture", run_writes, DEPTH);
        chk(!data_avail && !tx_valid, "R7 idle after drain", data_avail, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk_rd);
        chk(!buf_we && !buf_re && !tx_valid && !data_avail && !clk_half, "R10 reset",
            {buf_we, buf_re, tx_valid, data_avail, clk_half}, 0);
        @(negedge clk_smp) rst_smp = 1'b0;
        @(negedge clk_rd)  rst_rd  = 1'b0;
        repeat (5) @(negedge clk_rd);
        chk(!buf_we && !data_avail, "R10 idle after reset", {buf_we, data_avail}, 0);
        run(2'b00, 1'b1);
        run(2'b11, 1'b0);
        run(2'b01, 1'b0);
        run(2'b10, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk_rd);
        checks++;
        failures++;
        $display("FAIL watchdog expired actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule